// File: doc/BRIEF.md
# Event-driven output set/clear resolver

This block owns four registered timer outputs. On every clock it receives, per output, a set request and a clear request that upstream event logic has already reduced from the matched events, and it decides the level each output takes after the edge. When both requests reach the same output in one cycle, a programmable two-bit policy for that output settles the conflict. The policy can keep the level, force it high, force it low, or toggle it. Programming the toggle policy and routing one event to both the set and clear masks therefore makes that event toggle the output.

A second per-output field ties the requests to counter direction. While the selected counter counts down, set and clear trade places. The selectable counters are the low half (or the combined counter when the halves are unified) and the high half. The counter direction flags and the unify flag are inputs. Two 8-bit control words, each written through a 32-bit write port, hold the policy fields and the direction fields. A new value takes effect from the cycle after the write.

Top module: `evt_out_resolver`

## Requirements
- R1: After reset all outputs are low and both control words are zero. With zero control words, a simultaneous set and clear leaves the output unchanged.
- R2: If exactly one of set or clear is active after any swap, the output becomes high (set) or low (clear) on the next edge, whatever the policy field holds. If neither is active, the output holds.
- R3: When set and clear are both active for an output and no swap applies, policy code 0 keeps the output, code 1 drives it high and code 2 drives it low.
- R4: When set and clear are both active, policy code 3 inverts the output. This holds whether or not a swap applies.
- R5: A write with wr_sel=0 loads the policy word and a write with wr_sel=1 loads the direction word. The field for output n sits at bits [2n+1:2n] of the written data. Bits 31:8 are ignored.
- R6: Direction code 1 swaps set and clear for that output in every cycle in which cnt_lo_down is high, and in no other cycle. The flag is taken from the same cycle as the requests.
- R7: Direction code 2 swaps set and clear in cycles where cnt_hi_down is high and cnt_unified is low. When cnt_unified is high, code 2 acts like code 0.
- R8: Direction code 3 acts like code 0, so no swap ever applies.
- R9: While a swap applies and both requests are active, policy code 1 drives the output low and code 2 drives it high.
- R10: A control write changes behaviour from the following cycle onward. Requests in the write cycle are resolved with the old control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Control write strobe |
| wr_sel | input | 1 | 0 selects the policy word, 1 selects the direction word |
| wr_data | input | 32 | Write data; bits 7:0 are used |
| set_req | input | 4 | Per-output set request |
| clr_req | input | 4 | Per-output clear request |
| cnt_lo_down | input | 1 | Low (or unified) counter is counting down |
| cnt_hi_down | input | 1 | High counter is counting down |
| cnt_unified | input | 1 | Counters are joined into one |
| out_q | output | 4 | Registered output levels |

## Verification
The hardest case to reach is a swapped conflict under each policy code. It needs three things in the same cycle: a matching direction code already loaded, the right counter flag, and both requests together, with the unify flag deciding whether the high counter counts. The bench programs each output with a different policy code through one write. It then steps the direction word through codes 1, 2 and 3 while toggling both counter flags and the unify flag, and drives all-conflict cycles in between. A long randomised phase also writes random control words in the same cycles as requests, which exercises the write-timing rule against the reference model.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int unsigned FLD_W = 2;

  typedef enum logic [FLD_W-1:0] {
    POL_KEEP = 2'd0,
    POL_SET  = 2'd1,
    POL_CLR  = 2'd2,
    POL_FLIP = 2'd3
  } pol_e;

  typedef enum logic [FLD_W-1:0] {
    DIR_NONE = 2'd0,
    DIR_LO   = 2'd1,
    DIR_HI   = 2'd2,
    DIR_RSVD = 2'd3
  } dir_e;
endpackage

// File: rtl/evr_cfg.sv
module evr_cfg #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CFG_W-1:0]  pol_o,
  output logic [CFG_W-1:0]  dir_o
);
  logic [CFG_W-1:0] pol_q, pol_d;
  logic [CFG_W-1:0] dir_q, dir_d;
  logic             pol_en, dir_en;

  always_comb begin
    pol_en = wr_en && !wr_sel;
    dir_en = wr_en && wr_sel;
    pol_d  = wr_data[CFG_W-1:0];
    dir_d  = wr_data[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
      dir_q <= '0;
    end else begin
      if (pol_en) pol_q <= pol_d;
      if (dir_en) dir_q <= dir_d;
    end
  end

  assign pol_o = pol_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/evr_lane.sv
module evr_lane
  import evr_pkg::*;
(
  input  logic             cur_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [FLD_W-1:0] pol_i,
  input  logic [FLD_W-1:0] dir_i,
  input  logic             lo_dn_i,
  input  logic             hi_dn_i,
  input  logic             unified_i,
  output logic             nxt_o,
  output logic             act_o
);
  logic swap;
  logic eff_set, eff_clr;

  always_comb begin
    unique case (dir_e'(dir_i))
      DIR_LO:  swap = lo_dn_i;
      DIR_HI:  swap = hi_dn_i && !unified_i;
      default: swap = 1'b0;
    endcase
    eff_set = swap ? clr_i : set_i;
    eff_clr = swap ? set_i : clr_i;
    act_o   = set_i || clr_i;
    nxt_o   = cur_i;
    if (eff_set && !eff_clr) begin
      nxt_o = 1'b1;
    end else if (eff_clr && !eff_set) begin
      nxt_o = 1'b0;
    end else if (eff_set && eff_clr) begin
      unique case (pol_e'(pol_i))
        POL_SET:  nxt_o = !swap;
        POL_CLR:  nxt_o = swap;
        POL_FLIP: nxt_o = !cur_i;
        default:  nxt_o = cur_i;
      endcase
    end
  end
endmodule

// File: rtl/evr_outreg.sv
module evr_outreg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_r[g] <= 1'b0;
      else if (en_i[g]) q_r[g] <= d_i[g];
    end
  end

  assign q_o = q_r;
endmodule

// File: rtl/evt_out_resolver.sv
module evt_out_resolver
  import evr_pkg::*;
#(
  parameter int unsigned NUM_OUT = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [NUM_OUT-1:0] set_req,
  input  logic [NUM_OUT-1:0] clr_req,
  input  logic               cnt_lo_down,
  input  logic               cnt_hi_down,
  input  logic               cnt_unified,
  output logic [NUM_OUT-1:0] out_q
);
  localparam int unsigned CFG_W = NUM_OUT * FLD_W;

  logic [CFG_W-1:0]   pol_w, dir_w;
  logic [NUM_OUT-1:0] nxt_w, act_w;

  evr_cfg #(.DATA_W(DATA_W), .CFG_W(CFG_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .pol_o   (pol_w),
    .dir_o   (dir_w)
  );

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_lane
    evr_lane u_lane (
      .cur_i     (out_q[n]),
      .set_i     (set_req[n]),
      .clr_i     (clr_req[n]),
      .pol_i     (pol_w[FLD_W*n +: FLD_W]),
      .dir_i     (dir_w[FLD_W*n +: FLD_W]),
      .lo_dn_i   (cnt_lo_down),
      .hi_dn_i   (cnt_hi_down),
      .unified_i (cnt_unified),
      .nxt_o     (nxt_w[n]),
      .act_o     (act_w[n])
    );
  end

  evr_outreg #(.W(NUM_OUT)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (act_w),
    .d_i   (nxt_w),
    .q_o   (out_q)
  );
endmodule

// File: rtl/evr_resolver_chk.sv
module evr_resolver_chk #(
  parameter int unsigned NUM_OUT = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_OUT-1:0]   set_req,
  input logic [NUM_OUT-1:0]   clr_req,
  input logic                 cnt_lo_down,
  input logic [2*NUM_OUT-1:0] pol_q,
  input logic [2*NUM_OUT-1:0] dir_q,
  input logic [NUM_OUT-1:0]   out_q
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
    // R2: no request holds the level
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_req[i] && !clr_req[i]) |=> $stable(out_q[i]));
    // R2: a lone request with no direction coupling is applied
    p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_req[i] ^ clr_req[i]) && dir_q[2*i +: 2] == 2'd0)
        |=> out_q[i] == $past(set_req[i]));
    // R3: keep policy on conflict
    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_req[i] && clr_req[i] && pol_q[2*i +: 2] == 2'd0) |=> $stable(out_q[i]));
    // R4: toggle policy on conflict
    p_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (set_req[i] && clr_req[i] && pol_q[2*i +: 2] == 2'd3)
        |=> out_q[i] != $past(out_q[i]));
    // R6: low-counter coupling swaps a lone request
    p_lo_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_req[i] ^ clr_req[i]) && dir_q[2*i +: 2] == 2'd1 && cnt_lo_down)
        |=> out_q[i] == $past(clr_req[i]));
  end
endmodule

bind evt_out_resolver evr_resolver_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .set_req     (set_req),
  .clr_req     (clr_req),
  .cnt_lo_down (cnt_lo_down),
  .pol_q       (pol_w),
  .dir_q       (dir_w),
  .out_q       (out_q)
);

// File: tb/sim_evt_out_resolver.sv
module sim_evt_out_resolver;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [N-1:0] set_req = '0, clr_req = '0;
  logic lo = 1'b0, hi = 1'b0, un = 1'b0;
  logic [N-1:0] out_q;

  int total = 0, bad = 0;
  int m_pol[N], m_dir[N];
  bit m_out[N];

  always #5 clk = ~clk;

  evt_out_resolver u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .set_req(set_req), .clr_req(clr_req), .cnt_lo_down(lo), .cnt_hi_down(hi),
    .cnt_unified(un), .out_q(out_q)
  );

  function automatic bit model_next(int k);
    bit sw, s, c;
    sw = (m_dir[k] == 1 && lo) || (m_dir[k] == 2 && hi && !un);
    s = sw ? clr_req[k] : set_req[k];
    c = sw ? set_req[k] : clr_req[k];
    if (s && !c) return 1'b1;
    if (c && !s) return 1'b0;
    if (!s && !c) return m_out[k];
    case (m_pol[k])
      1: return !sw;
      2: return sw;
      3: return !m_out[k];
      default: return m_out[k];
    endcase
  endfunction

  task automatic compare(string tag);
    logic [N-1:0] e;
    for (int k = 0; k < N; k++) e[k] = m_out[k];
    total++;
    if (out_q !== e) begin
      bad++;
      $display("FAIL %s: out_q=%b expected=%b", tag, out_q, e);
    end
  endtask

  task automatic step(bit we, bit ws, logic [31:0] wd, logic [N-1:0] s, logic [N-1:0] c,
                      bit l, bit h, bit u, string tag);
    bit nx[N];
    @(negedge clk);
    wr_en = we; wr_sel = ws; wr_data = wd;
    set_req = s; clr_req = c; lo = l; hi = h; un = u;
    @(posedge clk);
    for (int k = 0; k < N; k++) nx[k] = model_next(k);
    for (int k = 0; k < N; k++) m_out[k] = nx[k];
    if (we) for (int k = 0; k < N; k++) begin
      if (!ws) m_pol[k] = int'(wd[2*k +: 2]);
      else     m_dir[k] = int'(wd[2*k +: 2]);
    end
    #1 compare(tag);
  endtask

  initial begin
    #(10 * 100000);
    bad++;
    $display("FAIL watchdog: out_q=%b expected=finish", out_q);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin m_pol[k] = 0; m_dir[k] = 0; m_out[k] = 0; end
    #23;
    compare("R1 reset low");
    @(negedge clk); rst_n = 1'b1;
    // R1: zero controls, conflict keeps
    step(0,0,0, 4'hF, 4'hF, 0,0,0, "R1 conflict keep after reset");
    // R2
    step(0,0,0, 4'b0101, 4'b0000, 0,0,0, "R2 lone set");
    step(0,0,0, 4'b0000, 4'b0000, 1,1,0, "R2 idle hold");
    step(0,0,0, 4'b0000, 4'b0001, 0,0,0, "R2 lone clear");
    // R5: policy per field, upper bits ignored: out0=0 out1=1 out2=2 out3=3
    step(1,0,32'hFFFF_FFE4, 4'h0, 4'h0, 0,0,0, "R5 policy write");
    step(0,0,0, 4'hF, 4'hF, 0,0,0, "R3 conflict keep/set/clear, R4 flip");
    step(0,0,0, 4'hF, 4'hF, 0,0,0, "R4 flip again");
    step(0,0,0, 4'b0010, 4'b0010, 0,0,0, "R3 code1 sets");
    // R6: direction code 1 everywhere
    step(1,1,32'hABCD_EF55, 4'h0, 4'h0, 0,0,0, "R5 direction write");
    step(0,0,0, 4'hF, 4'h0, 1,0,0, "R6 swapped lone set clears");
    step(0,0,0, 4'hF, 4'hF, 1,0,0, "R9 swapped code1 clears code2 sets, R4");
    step(0,0,0, 4'hF, 4'h0, 0,0,0, "R6 no swap when counting up");
    step(0,0,0, 4'h0, 4'hF, 1,0,0, "R6 swapped lone clear sets");
    // R7: direction code 2
    step(1,1,32'h0000_00AA, 4'h0, 4'h0, 0,0,0, "R7 dir write");
    step(0,0,0, 4'h0, 4'hF, 1,1,0, "R7 hi down swaps");
    step(0,0,0, 4'hF, 4'h0, 0,1,1, "R7 unified disables swap");
    step(0,0,0, 4'hF, 4'hF, 0,1,0, "R9 R7 swapped conflict");
    step(0,0,0, 4'h0, 4'hF, 1,0,0, "R7 lo flag ignored");
    // R8
    step(1,1,32'h0000_00FF, 4'h0, 4'h0, 0,0,0, "R8 dir write");
    step(0,0,0, 4'hF, 4'h0, 1,1,0, "R8 reserved no swap");
    step(0,0,0, 4'hF, 4'hF, 1,1,0, "R8 reserved conflict unswapped");
    // R10: write coincides with request
    step(1,0,32'h0000_0000, 4'hF, 4'hF, 0,0,0, "R10 old policy in write cycle");
    step(0,0,0, 4'hF, 4'hF, 0,0,0, "R10 new policy next cycle");
    step(1,1,32'h0000_0055, 4'h0, 4'h5, 1,0,0, "R10 old direction in write cycle");
    step(0,0,0, 4'h0, 4'h5, 1,0,0, "R10 new direction next cycle");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1] & r[2], r[3], $urandom, N'($urandom), N'($urandom),
           r[4], r[5], r[6], "random R2 R3 R4 R6 R7 R9 R10");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule